// File: doc/BRIEF.md
# Inter-Crate Block Copy Engine

This block copies a run of 32-bit words from one memory to another without help from the controlling processor. The processor programs a source start address, a destination start address and a length in bytes through a small register port, then writes a start command. From then on the engine alternates single-word read cycles on the source side with single-word write cycles on the destination side, moving each word in parallel. Each transfer finishes in a fixed state: done, plus error flags and an interrupt request toward the master.

Every word read carries a parity bit, and the engine checks it before it forwards the word. Each word written goes out with freshly generated parity. The source end and the destination end each keep their own count of the words they handled. The engine compares both counts with its own expected value once the last word has moved. For writes that go to several memories at once, the engine can issue the write acknowledge itself instead of waiting for a single target to answer. Throughput is bounded by the memory cycle time of the two ends, because each word costs one read handshake and one write handshake.

Top module: `btx_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, irq_o, par_err_o, src_cnt_err_o, dst_cnt_err_o, rd_req_o and wr_req_o are all 0.
- R2: Register writes use cfg_addr_i 0 for the source start address, 1 for the destination start address, 2 for the byte count and 3 for control, where control bit 0 starts a transfer and control bit 1 selects broadcast writes. While busy_o is 1, writes to any register, including a start, have no effect.
- R3: A transfer moves ceil(bytes/4) words. Reads use ascending source addresses in steps of 4 from the source start, and writes use ascending destination addresses in steps of 4 from the destination start. Each word is written with the value that was read.
- R4: A byte count of 0 finishes the transfer with done_o set within two cycles of the start, with no read or write cycle.
- R5: At most one of rd_req_o and wr_req_o is high at a time. A read request stays high until rd_ack_i. In normal mode a write request stays high until wr_ack_i.
- R6: Parity is even: rd_par_i must equal the XOR of the 32 bits of rd_data_i, and wr_par_o equals the XOR of the 32 bits of wr_data_o.
- R7: A read whose parity check fails ends the transfer at once. The failing word is not written, no further cycles start, and done_o, par_err_o and irq_o become 1.
- R8: After the last word, src_words_i is compared with the expected word count, and a difference sets src_cnt_err_o. dst_words_i is compared the same way and sets dst_cnt_err_o. Either flag comes with done_o and irq_o.
- R9: In broadcast mode each write cycle lasts one clock, with wr_ack_o high for exactly that clock. wr_ack_i is not waited for.
- R10: done_o, the error flags and irq_o stay set after a transfer ends and are cleared by the next accepted start. irq_o is never high without done_o.
- R11: busy_o is 1 from the clock after an accepted start until the clock at which done_o rises, and done_o is 0 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | ADDR_W | Register write data |
| rd_req_o | output | 1 | Source read request |
| rd_addr_o | output | ADDR_W | Source byte address |
| rd_ack_i | input | 1 | Source read acknowledge, data valid |
| rd_data_i | input | DATA_W | Source read data |
| rd_par_i | input | 1 | Source parity bit |
| wr_req_o | output | 1 | Destination write request |
| wr_addr_o | output | ADDR_W | Destination byte address |
| wr_data_o | output | DATA_W | Destination write data |
| wr_par_o | output | 1 | Generated parity bit for wr_data_o |
| wr_ack_i | input | 1 | Destination write acknowledge |
| wr_ack_o | output | 1 | Acknowledge driven by the engine in broadcast mode |
| src_words_i | input | WCNT_W | Word count reported by the source end |
| dst_words_i | input | WCNT_W | Word count reported by the destination end |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished |
| par_err_o | output | 1 | Last transfer stopped on a parity error |
| src_cnt_err_o | output | 1 | Source end count differed |
| dst_cnt_err_o | output | 1 | Destination end count differed |
| irq_o | output | 1 | Interrupt request toward the master |

## Verification
The bench builds the engine with its default parameters: 24-bit addresses, 32-bit words and a 16-bit byte count. That gives a word counter of 15 bits, so lengths from 0 to 160 bytes cover the zero case, rounding of partial words and multi-word runs with random handshake delays. The source and destination models behind the ports report their own word counts, and the bench can skew either one. It can also corrupt the parity of a chosen word, so the count-mismatch and early-stop paths are reached without changing the engine.

// File: rtl/btx_pkg.sv
package btx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CHECK = 2'd3
    } btx_state_e;

    // Register select codes on the configuration port
    localparam logic [1:0] REG_SRC   = 2'd0;
    localparam logic [1:0] REG_DST   = 2'd1;
    localparam logic [1:0] REG_BYTES = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    // Control register bit positions
    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_BCAST_BIT = 1;

endpackage

// File: rtl/btx_parity.sv
module btx_parity #(
    parameter int  WIDTH = 32,
    parameter bit  ODD   = 1'b0
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             par_o
);

    generate
        if (ODD) begin : g_odd
            assign par_o = ~(^data_i);
        end else begin : g_even
            assign par_o = ^data_i;
        end
    endgenerate

endmodule

// File: rtl/btx_seq.sv
module btx_seq
    import btx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int WCNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bcast_i,
    input  logic [ADDR_W-1:0] src_base_i,
    input  logic [ADDR_W-1:0] dst_base_i,
    input  logic [WCNT_W-1:0] words_i,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_par_ok_i,
    input  logic              wr_ack_i,
    input  logic [WCNT_W-1:0] src_words_i,
    input  logic [WCNT_W-1:0] dst_words_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_ack_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic              fin_par_err_o,
    output logic              fin_src_err_o,
    output logic              fin_dst_err_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    typedef struct packed {
        btx_state_e        st;
        logic [ADDR_W-1:0] rd_addr;
        logic [ADDR_W-1:0] wr_addr;
        logic [WCNT_W-1:0] left;
        logic [WCNT_W-1:0] total;
        logic [DATA_W-1:0] data;
        logic              bcast;
    } seq_s;

    seq_s seq_d, seq_q;
    logic fin_d, fpar_d, fsrc_d, fdst_d;

    always_comb begin
        seq_d  = seq_q;
        fin_d  = 1'b0;
        fpar_d = 1'b0;
        fsrc_d = 1'b0;
        fdst_d = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.rd_addr = src_base_i;
                    seq_d.wr_addr = dst_base_i;
                    seq_d.left    = words_i;
                    seq_d.total   = words_i;
                    seq_d.bcast   = bcast_i;
                    seq_d.st      = (words_i == '0) ? ST_CHECK : ST_READ;
                end
            end
            ST_READ: begin
                if (rd_ack_i) begin
                    if (!rd_par_ok_i) begin
                        fin_d    = 1'b1;
                        fpar_d   = 1'b1;
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.data    = rd_data_i;
                        seq_d.rd_addr = seq_q.rd_addr + STEP;
                        seq_d.st      = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (seq_q.bcast || wr_ack_i) begin
                    seq_d.wr_addr = seq_q.wr_addr + STEP;
                    seq_d.left    = seq_q.left - 1'b1;
                    seq_d.st      = (seq_q.left == WCNT_W'(1)) ? ST_CHECK : ST_READ;
                end
            end
            ST_CHECK: begin
                fin_d    = 1'b1;
                fsrc_d   = (src_words_i != seq_q.total);
                fdst_d   = (dst_words_i != seq_q.total);
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req_o      = (seq_q.st == ST_READ);
    assign rd_addr_o     = seq_q.rd_addr;
    assign wr_req_o      = (seq_q.st == ST_WRITE);
    assign wr_addr_o     = seq_q.wr_addr;
    assign wr_data_o     = seq_q.data;
    assign wr_ack_o      = (seq_q.st == ST_WRITE) && seq_q.bcast;
    assign busy_o        = (seq_q.st != ST_IDLE);
    assign fin_o         = fin_d;
    assign fin_par_err_o = fpar_d;
    assign fin_src_err_o = fsrc_d;
    assign fin_dst_err_o = fdst_d;

endmodule

// File: rtl/btx_engine.sv
module btx_engine
    import btx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int BPW_LOG = $clog2(DATA_W / 8),
    localparam int WCNT_W  = CNT_W - BPW_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [ADDR_W-1:0] cfg_wdata_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_par_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_par_o,
    input  logic              wr_ack_i,
    output logic              wr_ack_o,
    input  logic [WCNT_W-1:0] src_words_i,
    input  logic [WCNT_W-1:0] dst_words_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              par_err_o,
    output logic              src_cnt_err_o,
    output logic              dst_cnt_err_o,
    output logic              irq_o
);

    localparam logic [CNT_W:0] ROUND_UP = (CNT_W+1)'((1 << BPW_LOG) - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  bytes;
        logic              done;
        logic              par_err;
        logic              src_err;
        logic              dst_err;
        logic              irq;
    } regs_s;

    regs_s regs_d, regs_q;

    logic              busy;
    logic              start;
    logic              bcast_req;
    logic [WCNT_W-1:0] words;
    logic              rd_par_calc;
    logic              rd_par_ok;
    logic              fin, fin_par, fin_src, fin_dst;

    // Byte count rounded up to whole words
    assign words = WCNT_W'(({1'b0, regs_q.bytes} + ROUND_UP) >> BPW_LOG);

    assign start     = cfg_wr_i && !busy && (cfg_addr_i == REG_CTRL)
                       && cfg_wdata_i[CTRL_GO_BIT];
    assign bcast_req = cfg_wdata_i[CTRL_BCAST_BIT];

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr_i && !busy) begin
            case (cfg_addr_i)
                REG_SRC:   regs_d.src   = cfg_wdata_i;
                REG_DST:   regs_d.dst   = cfg_wdata_i;
                REG_BYTES: regs_d.bytes = cfg_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        if (start) begin
            regs_d.done    = 1'b0;
            regs_d.par_err = 1'b0;
            regs_d.src_err = 1'b0;
            regs_d.dst_err = 1'b0;
            regs_d.irq     = 1'b0;
        end
        if (fin) begin
            regs_d.done    = 1'b1;
            regs_d.par_err = fin_par;
            regs_d.src_err = fin_src;
            regs_d.dst_err = fin_dst;
            regs_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    btx_parity #(.WIDTH(DATA_W), .ODD(1'b0)) u_rd_par (
        .data_i (rd_data_i),
        .par_o  (rd_par_calc)
    );

    assign rd_par_ok = (rd_par_calc == rd_par_i);

    btx_parity #(.WIDTH(DATA_W), .ODD(1'b0)) u_wr_par (
        .data_i (wr_data_o),
        .par_o  (wr_par_o)
    );

    btx_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WCNT_W (WCNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .bcast_i       (bcast_req),
        .src_base_i    (regs_q.src),
        .dst_base_i    (regs_q.dst),
        .words_i       (words),
        .rd_ack_i      (rd_ack_i),
        .rd_data_i     (rd_data_i),
        .rd_par_ok_i   (rd_par_ok),
        .wr_ack_i      (wr_ack_i),
        .src_words_i   (src_words_i),
        .dst_words_i   (dst_words_i),
        .rd_req_o      (rd_req_o),
        .rd_addr_o     (rd_addr_o),
        .wr_req_o      (wr_req_o),
        .wr_addr_o     (wr_addr_o),
        .wr_data_o     (wr_data_o),
        .wr_ack_o      (wr_ack_o),
        .busy_o        (busy),
        .fin_o         (fin),
        .fin_par_err_o (fin_par),
        .fin_src_err_o (fin_src),
        .fin_dst_err_o (fin_dst)
    );

    assign busy_o        = busy;
    assign done_o        = regs_q.done;
    assign par_err_o     = regs_q.par_err;
    assign src_cnt_err_o = regs_q.src_err;
    assign dst_cnt_err_o = regs_q.dst_err;
    assign irq_o         = regs_q.irq;

endmodule

// File: rtl/btx_engine_chk.sv
module btx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req_o,
    input logic rd_ack_i,
    input logic wr_req_o,
    input logic wr_ack_i,
    input logic wr_ack_o,
    input logic busy_o,
    input logic done_o,
    input logic par_err_o,
    input logic irq_o
);

    assert_one_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o);

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i && !wr_ack_o |=> wr_req_o);

    assert_bcast_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack_o |-> wr_req_o);

    assert_bcast_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack_o |=> !wr_ack_o);

    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);

    assert_busy_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    assert_par_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err_o) |-> $past(rd_ack_i));

    assert_par_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> !rd_req_o && !wr_req_o);

endmodule

bind btx_engine btx_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .wr_req_o  (wr_req_o),
    .wr_ack_i  (wr_ack_i),
    .wr_ack_o  (wr_ack_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .par_err_o (par_err_o),
    .irq_o     (irq_o)
);

// File: tb/btx_engine_tb_top.sv
module btx_engine_tb_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int WCNT_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_i = 1'b0;
    logic [1:0]        cfg_addr_i = '0;
    logic [ADDR_W-1:0] cfg_wdata_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              rd_par_i = 1'b0;
    logic              wr_req_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [DATA_W-1:0] wr_data_o;
    logic              wr_par_o;
    logic              wr_ack_i = 1'b0;
    logic              wr_ack_o;
    logic [WCNT_W-1:0] src_words_i;
    logic [WCNT_W-1:0] dst_words_i;
    logic              busy_o, done_o, par_err_o, src_cnt_err_o, dst_cnt_err_o, irq_o;

    always #4 clk = ~clk;

    // Bench-side model state
    logic [DATA_W-1:0] smem [64];
    logic [DATA_W-1:0] dmem [64];
    int src_seen, dst_seen, inj_idx, src_bias, dst_bias;
    int addr_bad, par_bad, bc_acks, stray_wr;
    bit bc_mode;
    logic [ADDR_W-1:0] exp_rd_addr, exp_wr_addr;
    int checks = 0;
    int fails  = 0;

    assign src_words_i = WCNT_W'(src_seen + src_bias);
    assign dst_words_i = WCNT_W'(dst_seen + dst_bias);

    btx_engine dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_i (cfg_wr_i), .cfg_addr_i (cfg_addr_i), .cfg_wdata_i (cfg_wdata_i),
        .rd_req_o (rd_req_o), .rd_addr_o (rd_addr_o), .rd_ack_i (rd_ack_i),
        .rd_data_i (rd_data_i), .rd_par_i (rd_par_i),
        .wr_req_o (wr_req_o), .wr_addr_o (wr_addr_o), .wr_data_o (wr_data_o),
        .wr_par_o (wr_par_o), .wr_ack_i (wr_ack_i), .wr_ack_o (wr_ack_o),
        .src_words_i (src_words_i), .dst_words_i (dst_words_i),
        .busy_o (busy_o), .done_o (done_o), .par_err_o (par_err_o),
        .src_cnt_err_o (src_cnt_err_o), .dst_cnt_err_o (dst_cnt_err_o), .irq_o (irq_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_words(input int bytes);
        return (bytes + 3) / 4;
    endfunction

    // Source and destination memory models, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (rd_req_o && $urandom_range(0, 2) != 0) begin
                if (rd_addr_o != exp_rd_addr) addr_bad++;
                exp_rd_addr = exp_rd_addr + 4;
                rd_data_i = smem[rd_addr_o[7:2]];
                rd_par_i  = (^rd_data_i) ^ (src_seen == inj_idx);
                src_seen++;
                rd_ack_i = 1'b1;
            end
            if (wr_ack_i) begin
                wr_ack_i = 1'b0;
            end else if (wr_req_o && !bc_mode && $urandom_range(0, 2) != 0) begin
                if (wr_addr_o != exp_wr_addr) addr_bad++;
                if (wr_par_o != ^wr_data_o) par_bad++;
                exp_wr_addr = exp_wr_addr + 4;
                dmem[wr_addr_o[7:2]] = wr_data_o;
                dst_seen++;
                wr_ack_i = 1'b1;
            end
            if (wr_ack_o) begin
                bc_acks++;
                if (!bc_mode || !wr_req_o) stray_wr++;
                if (wr_addr_o != exp_wr_addr) addr_bad++;
                if (wr_par_o != ^wr_data_o) par_bad++;
                exp_wr_addr = exp_wr_addr + 4;
                dmem[wr_addr_o[7:2]] = wr_data_o;
                dst_seen++;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic arm(input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst,
                       input bit bc, input int inj, input int sb, input int db);
        src_seen = 0; dst_seen = 0; inj_idx = inj; src_bias = sb; dst_bias = db;
        addr_bad = 0; par_bad = 0; bc_acks = 0; stray_wr = 0; bc_mode = bc;
        exp_rd_addr = src; exp_wr_addr = dst;
        for (int i = 0; i < 64; i++) begin
            smem[i] = $urandom;
            dmem[i] = ~smem[i];
        end
    endtask

    task automatic start_xfer(input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst,
                              input int bytes, input bit bc, input int inj,
                              input int sb, input int db);
        arm(src, dst, bc, inj, sb, db);
        cfg_write(2'd0, src);
        cfg_write(2'd1, dst);
        cfg_write(2'd2, ADDR_W'(bytes));
        cfg_write(2'd3, {{(ADDR_W-2){1'b0}}, bc, 1'b1});
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_copy(input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst,
                              input int nw, input string req);
        int bad = 0;
        for (int k = 0; k < nw; k++) begin
            if (dmem[((dst >> 2) + k) & 63] != smem[((src >> 2) + k) & 63]) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic full_run(input int bytes, input bit bc, input string req);
        logic [ADDR_W-1:0] s = 24'h001000 + ADDR_W'($urandom_range(0, 20) * 4);
        logic [ADDR_W-1:0] d = 24'h002000 + ADDR_W'($urandom_range(0, 20) * 4);
        int nw = exp_words(bytes);
        start_xfer(s, d, bytes, bc, -1, 0, 0);
        chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
        wait_done();
        chk(done_o && irq_o && !par_err_o && !src_cnt_err_o && !dst_cnt_err_o,
            {req, " R8 clean finish"},
            {done_o, irq_o, par_err_o, src_cnt_err_o, dst_cnt_err_o}, 5'b11000);
        chk(dst_seen == nw && src_seen == nw, {req, " R3 word count"}, dst_seen, nw);
        chk(addr_bad == 0, {req, " R3 address order"}, addr_bad, 0);
        chk(par_bad == 0, {req, " R6 write parity"}, par_bad, 0);
        check_copy(s, d, nw, {req, " R3 data"});
        if (bc) chk(bc_acks == nw && stray_wr == 0, {req, " R9 broadcast acks"}, bc_acks, nw);
        else    chk(bc_acks == 0, {req, " R9 no self ack"}, bc_acks, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        #(8 * 190000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        arm(24'h0, 24'h0, 1'b0, -1, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({busy_o, done_o, irq_o, par_err_o, src_cnt_err_o, dst_cnt_err_o, rd_req_o, wr_req_o} == 8'b0,
            "R1 reset state",
            {busy_o, done_o, irq_o, par_err_o, src_cnt_err_o, dst_cnt_err_o, rd_req_o, wr_req_o}, 0);

        // Directed lengths, normal mode: R3 rounding of partial words
        full_run(4, 1'b0, "R3 one word");
        full_run(13, 1'b0, "R3 13 bytes");
        full_run(1, 1'b0, "R3 1 byte");

        // R10 start clears status and irq
        start_xfer(24'h001000, 24'h002000, 8, 1'b0, -1, 0, 0);
        chk(!irq_o && !done_o, "R10 start clears irq/done", {irq_o, done_o}, 0);
        wait_done();
        chk(irq_o && done_o, "R10 irq held after finish", {irq_o, done_o}, 2'b11);
        repeat (5) @(negedge clk);
        chk(irq_o && done_o, "R10 irq sticky", {irq_o, done_o}, 2'b11);

        // R4 zero byte count
        start_xfer(24'h001000, 24'h002000, 0, 1'b0, -1, 0, 0);
        @(negedge clk);
        chk(done_o && irq_o, "R4 zero count done quickly", {done_o, irq_o}, 2'b11);
        chk(src_seen == 0 && dst_seen == 0, "R4 no bus cycles", src_seen + dst_seen, 0);

        // R9 broadcast mode
        full_run(24, 1'b1, "R9 broadcast");

        // R7 parity error on third word of five
        start_xfer(24'h001000, 24'h002000, 20, 1'b0, 2, 0, 0);
        wait_done();
        repeat (4) @(negedge clk);
        chk(par_err_o && done_o && irq_o, "R7 parity flags", {par_err_o, done_o, irq_o}, 3'b111);
        chk(src_seen == 3 && dst_seen == 2, "R7 stop after bad word", {src_seen, dst_seen}, {32'd3, 32'd2});
        chk(dmem[(24'h002000 >> 2) + 2 & 63] == ~smem[(24'h001000 >> 2) + 2 & 63],
            "R7 bad word not written", dmem[(24'h002000 >> 2) + 2 & 63], ~smem[(24'h001000 >> 2) + 2 & 63]);
        chk(!src_cnt_err_o && !dst_cnt_err_o, "R7 no count check", {src_cnt_err_o, dst_cnt_err_o}, 0);

        // R6 parity error injected on first word
        start_xfer(24'h001000, 24'h002000, 8, 1'b0, 0, 0, 0);
        wait_done();
        chk(par_err_o && dst_seen == 0, "R6 first word parity", {par_err_o, dst_seen}, 1);

        // R8 source count mismatch
        start_xfer(24'h001000, 24'h002000, 12, 1'b0, -1, 1, 0);
        wait_done();
        chk(src_cnt_err_o && !dst_cnt_err_o && irq_o, "R8 source mismatch",
            {src_cnt_err_o, dst_cnt_err_o, irq_o}, 3'b101);

        // R8 destination count mismatch
        start_xfer(24'h001000, 24'h002000, 12, 1'b1, -1, 0, -1);
        wait_done();
        chk(!src_cnt_err_o && dst_cnt_err_o && irq_o, "R8 destination mismatch",
            {src_cnt_err_o, dst_cnt_err_o, irq_o}, 3'b011);

        // R2 writes while busy are ignored
        start_xfer(24'h001040, 24'h002040, 40, 1'b0, -1, 0, 0);
        cfg_write(2'd0, 24'h003000);
        cfg_write(2'd1, 24'h003800);
        cfg_write(2'd2, 24'd4);
        cfg_write(2'd3, 24'd3);
        wait_done();
        chk(dst_seen == 10 && addr_bad == 0 && bc_acks == 0, "R2 busy writes ignored",
            dst_seen, 10);
        check_copy(24'h001040, 24'h002040, 10, "R2 data intact");
        // Registers still hold the first program: restart without reprogramming
        arm(24'h001040, 24'h002040, 1'b0, -1, 0, 0);
        cfg_write(2'd3, 24'd1);
        wait_done();
        chk(dst_seen == 10 && addr_bad == 0, "R2 registers kept", dst_seen, 10);

        // Random mix
        for (int t = 0; t < 8; t++) begin
            full_run($urandom_range(1, 160), 1'($urandom_range(0, 1)), "R3 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule